// File: doc/BRIEF.md
# Multi-Source Event Timestamp Capture

This block watches a small set of asynchronous event inputs and records when each one changes. Every input passes through a two-flop synchroniser and an edge detector. Each source has its own enable and its own choice of rising and falling edges. One source, the general-purpose input, reacts to rising edges only.

Events are stamped against a free-running 24-bit time base that advances once per clock. Only a coarse slice of that time base is stored: 18 bits, each step being four clocks. Every event falling in the same four-clock slot is merged into a single record. A record holds the coarse time and a 6-bit source mask. Records go into an 8-deep queue, which a host drains one record per pop.

The queue reports empty, full and a sticky overflow flag. An interrupt request stays high while at least one record is waiting.

Top module: `evt_stamp_capture`

## Requirements
- R1: After reset the time base output reads 0. It then increases by exactly one on every clock and wraps at 2^24.
- R2: A level change on an input captured at clock edge k is stamped with bits [19:2] of the time-base value held after edge k+1. The stamp appears on `rd_ts_o`.
- R3: In `rd_tag_o`, bit i stands for source i, and bit 5 is always 0. All qualifying edges whose stamp cycles fall in one four-clock slot (same time-base bits [23:2]) produce exactly one record. That record is written at the slot's last clock, when time-base bits [1:0] equal 3, and its tag is the OR of the sources involved.
- R4: Edges in different slots give separate records, read back in the order they happened.
- R5: A source whose bit in `src_en_i` is 0 contributes no tag bit and creates no record.
- R6: A source produces a record on a rising edge when its `rise_en_i` bit is 1. It produces a record on a falling edge when its `fall_en_i` bit is 1.
- R7: Source 4 ignores falling edges whatever its `fall_en_i` bit says.
- R8: The queue holds up to 8 records. The oldest record is shown on the read outputs while the queue is not empty. Each `pop_i` cycle removes that record, and a pop while empty changes nothing.
- R9: `full_o` is high with 8 records. A record arriving while full with no pop that cycle is discarded and sets `ovf_o`. `ovf_o` stays set until a cycle with `ovf_clr_i` high.
- R10: `irq_o` is high exactly while the queue holds at least one record.
- R11: During and right after reset: `empty_o`=1, `full_o`=0, `ovf_o`=0, `irq_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 5 | Raw event inputs, asynchronous |
| src_en_i | input | 5 | Per-source capture enable |
| rise_en_i | input | 5 | Per-source rising-edge select |
| fall_en_i | input | 5 | Per-source falling-edge select (ignored for source 4) |
| pop_i | input | 1 | Remove the head record |
| ovf_clr_i | input | 1 | Clear the sticky overflow flag |
| rd_ts_o | output | 18 | Coarse timestamp of the head record |
| rd_tag_o | output | 6 | Source mask of the head record |
| empty_o | output | 1 | Queue holds no record |
| full_o | output | 1 | Queue holds 8 records |
| ovf_o | output | 1 | Sticky record-lost flag |
| irq_o | output | 1 | Record waiting |
| tbase_o | output | 24 | Current time-base value |

## Verification
The assertions assume that the enable and edge-select inputs stay steady while a captured edge is in the synchroniser. They also assume that `pop_i` is only meaningful as one request per clock. The stimulus changes those configuration inputs only after several idle clocks. It drives the event inputs at falling clock edges and holds each level for at least one full cycle, so both synchroniser stages see every change. Slot-merge cases are placed by waiting for a chosen time-base phase before driving.

// File: rtl/evt_cap_pkg.sv
package evt_cap_pkg;
    localparam int TS_W  = 18;
    localparam int TAG_W = 6;

    typedef struct packed {
        logic [TS_W-1:0]  ts;
        logic [TAG_W-1:0] tag;
    } cap_entry_t;
endpackage

// File: rtl/evt_timebase.sv
module evt_timebase #(
    parameter int TB_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TB_W-1:0] tb_o
);
    logic [TB_W-1:0] tb_d, tb_q;

    always_comb begin
        tb_d = tb_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign tb_o = tb_q;

    // R1
    tb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (tb_q == $past(tb_q) + 1'b1));
endmodule

// File: rtl/evt_edge_front.sv
module evt_edge_front #(
    parameter int           N_SRC     = 5,
    parameter logic [N_SRC-1:0] RISE_ONLY = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic [N_SRC-1:0] rise_en_i,
    input  logic [N_SRC-1:0] fall_en_i,
    output logic [N_SRC-1:0] hit_o
);
    typedef struct packed {
        logic [N_SRC-1:0] meta;
        logic [N_SRC-1:0] sync;
        logic [N_SRC-1:0] prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.meta = src_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        localparam logic ALLOW_FALL = !RISE_ONLY[i];
        logic rise_w, fall_w;
        assign rise_w   = st_q.sync[i] & ~st_q.prev[i];
        assign fall_w   = ~st_q.sync[i] & st_q.prev[i];
        assign hit_o[i] = en_i[i] & ((rise_w & rise_en_i[i]) |
                                     (fall_w & fall_en_i[i] & ALLOW_FALL));
    end
endmodule

// File: rtl/evt_slot_merge.sv
module evt_slot_merge
    import evt_cap_pkg::*;
#(
    parameter int N_SRC  = 5,
    parameter int TS_LSB = 2,
    localparam int IN_W  = TS_LSB + TS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  tb_i,
    input  logic [N_SRC-1:0] hit_i,
    output logic             wr_o,
    output cap_entry_t       entry_o
);
    logic [TAG_W-1:0] acc_d, acc_q;
    logic [TAG_W-1:0] tag_now;
    logic             slot_end;

    always_comb begin
        slot_end      = &tb_i[TS_LSB-1:0];
        tag_now       = acc_q | TAG_W'(hit_i);
        wr_o          = slot_end && (tag_now != '0);
        entry_o.ts    = tb_i[TS_LSB +: TS_W];
        entry_o.tag   = tag_now;
        acc_d         = slot_end ? '0 : tag_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/evt_cap_fifo.sv
module evt_cap_fifo
    import evt_cap_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  cap_entry_t din_i,
    input  logic       pop_i,
    input  logic       ovf_clr_i,
    output cap_entry_t dout_o,
    output logic       empty_o,
    output logic       full_o,
    output logic       ovf_o
);
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             ovf;
    } fifo_st_t;

    fifo_st_t   st_d, st_q;
    cap_entry_t mem_q [DEPTH];
    logic       do_push, do_pop, drop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop_i && (st_q.count != '0);
        do_push = push_i && ((st_q.count != CNT_W'(DEPTH)) || do_pop);
        drop    = push_i && !do_push;
        if (do_push) st_d.wr_ptr = bump(st_q.wr_ptr);
        if (do_pop)  st_d.rd_ptr = bump(st_q.rd_ptr);
        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
        if (drop)           st_d.ovf = 1'b1;
        else if (ovf_clr_i) st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr_ptr] <= din_i;
    end

    assign dout_o  = mem_q[st_q.rd_ptr];
    assign empty_o = (st_q.count == '0);
    assign full_o  = (st_q.count == CNT_W'(DEPTH));
    assign ovf_o   = st_q.ovf;

    // R8
    pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !empty_o && !push_i) |=> (st_q.count == $past(st_q.count) - 1'b1));
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> ovf_o);
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);
endmodule

// File: rtl/evt_stamp_capture.sv
module evt_stamp_capture
    import evt_cap_pkg::*;
#(
    parameter int               N_SRC     = 5,
    parameter int               TB_W      = 24,
    parameter int               TS_LSB    = 2,
    parameter int               DEPTH     = 8,
    parameter logic [N_SRC-1:0] RISE_ONLY = 5'b10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] src_en_i,
    input  logic [N_SRC-1:0] rise_en_i,
    input  logic [N_SRC-1:0] fall_en_i,
    input  logic             pop_i,
    input  logic             ovf_clr_i,
    output logic [TS_W-1:0]  rd_ts_o,
    output logic [TAG_W-1:0] rd_tag_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             ovf_o,
    output logic             irq_o,
    output logic [TB_W-1:0]  tbase_o
);
    localparam int SLICE_W = TS_LSB + TS_W;

    logic [TB_W-1:0]  tb;
    logic [N_SRC-1:0] hits;
    logic             wr_valid;
    cap_entry_t       wr_entry, head;

    evt_timebase #(.TB_W(TB_W)) u_tb (
        .clk  (clk),
        .rst_n(rst_n),
        .tb_o (tb)
    );

    evt_edge_front #(.N_SRC(N_SRC), .RISE_ONLY(RISE_ONLY)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .en_i     (src_en_i),
        .rise_en_i(rise_en_i),
        .fall_en_i(fall_en_i),
        .hit_o    (hits)
    );

    evt_slot_merge #(.N_SRC(N_SRC), .TS_LSB(TS_LSB)) u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .tb_i   (tb[SLICE_W-1:0]),
        .hit_i  (hits),
        .wr_o   (wr_valid),
        .entry_o(wr_entry)
    );

    evt_cap_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (wr_valid),
        .din_i    (wr_entry),
        .pop_i    (pop_i),
        .ovf_clr_i(ovf_clr_i),
        .dout_o   (head),
        .empty_o  (empty_o),
        .full_o   (full_o),
        .ovf_o    (ovf_o)
    );

    assign rd_ts_o  = head.ts;
    assign rd_tag_o = head.tag;
    assign irq_o    = !empty_o;
    assign tbase_o  = tb;

    // R3
    one_write_per_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);
    // R10
    irq_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(wr_valid));
endmodule

// File: tb/evt_stamp_capture_tb.sv
module evt_stamp_capture_tb_top;
    typedef struct packed {
        logic [21:0] slot;
        logic [5:0]  tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_i = '0;
    logic [4:0]  src_en_i = 5'h1f;
    logic [4:0]  rise_en_i = 5'h1f;
    logic [4:0]  fall_en_i = 5'h00;
    logic        pop_i = 1'b0;
    logic        ovf_clr_i = 1'b0;
    logic [17:0] rd_ts_o;
    logic [5:0]  rd_tag_o;
    logic        empty_o, full_o, ovf_o, irq_o;
    logic [23:0] tbase_o;

    int   checks = 0;
    int   errors = 0;
    logic mon_en = 1'b0;
    logic force_pop = 1'b0;
    logic [23:0] m_time = '0;
    exp_t q[$];

    always #10 clk = ~clk;

    evt_stamp_capture dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .src_en_i(src_en_i),
        .rise_en_i(rise_en_i), .fall_en_i(fall_en_i), .pop_i(pop_i),
        .ovf_clr_i(ovf_clr_i), .rd_ts_o(rd_ts_o), .rd_tag_o(rd_tag_o),
        .empty_o(empty_o), .full_o(full_o), .ovf_o(ovf_o), .irq_o(irq_o),
        .tbase_o(tbase_o)
    );

    always @(posedge clk) begin
        if (!rst_n) m_time <= '0;
        else        m_time <= m_time + 1'b1;
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_phase(input logic [1:0] p);
        while (m_time[1:0] != p) @(negedge clk);
    endtask

    // driver: called at a negedge, applies new levels and predicts the record
    task automatic fire(input logic [4:0] nv);
        logic [4:0]  rise, fall, tag;
        logic [23:0] t;
        exp_t        e;
        rise = nv & ~src_i;
        fall = ~nv & src_i;
        tag  = src_en_i & ((rise & rise_en_i) | (fall & fall_en_i & 5'b01111));
        src_i = nv;
        if (tag != '0) begin
            t = m_time + 24'd2;
            if (q.size() > 0 && q[$].slot == t[23:2]) begin
                q[$].tag = q[$].tag | {1'b0, tag};
            end else begin
                e.slot = t[23:2];
                e.tag  = {1'b0, tag};
                q.push_back(e);
            end
        end
    endtask

    // monitor: compares and pops each record as it appears
    always @(negedge clk) begin
        exp_t e;
        if (mon_en && rst_n && !empty_o) begin
            if (q.size() == 0) begin
                check(1'b0, "R4 unexpected record", {8'h0, rd_ts_o, rd_tag_o}, 32'h0);
            end else begin
                e = q.pop_front();
                check(rd_ts_o == e.slot[17:0], "R2 timestamp", 32'(rd_ts_o), 32'(e.slot[17:0]));
                check(rd_tag_o == e.tag, "R3 tag", 32'(rd_tag_o), 32'(e.tag));
                check(irq_o == 1'b1, "R10 irq with record", 32'(irq_o), 32'h1);
            end
            pop_i = 1'b1;
        end else begin
            pop_i = force_pop;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(4);
        check(empty_o == 1'b1, "R11 empty", 32'(empty_o), 32'h1);
        check(full_o == 1'b0, "R11 full", 32'(full_o), 32'h0);
        check(ovf_o == 1'b0, "R11 ovf", 32'(ovf_o), 32'h0);
        check(irq_o == 1'b0, "R11 irq", 32'(irq_o), 32'h0);
        check(tbase_o == 24'd0, "R1 reset value", 32'(tbase_o), 32'h0);
        rst_n = 1'b1;
        tick(3);
        check(tbase_o == m_time && m_time == 24'd3, "R1 count", 32'(tbase_o), 32'(m_time));
        check(empty_o == 1'b1, "R11 empty after reset", 32'(empty_o), 32'h1);
        tick(50);
        check(tbase_o == m_time, "R1 count later", 32'(tbase_o), 32'(m_time));
        mon_en = 1'b1;

        // R2 R4: each source alone, rising edges only
        for (int i = 0; i < 5; i++) begin
            fire(5'(1 << i)); tick(6);
            fire(5'b0);       tick(6);
        end

        // R3: simultaneous sources
        fire(5'b00111); tick(6); fire(5'b0); tick(8);

        // R3: same slot, different cycles
        wait_phase(2'd2); fire(5'b00001); tick(1); fire(5'b00011); tick(6);
        fire(5'b0); tick(8);

        // R4: slot boundary splits two edges
        wait_phase(2'd1); fire(5'b00100); tick(1); fire(5'b01100); tick(6);
        fire(5'b0); tick(8);

        // R6 R7: falling edges enabled; source 4 still rising only
        fall_en_i = 5'h1f; tick(4);
        fire(5'b10011); tick(6); fire(5'b0); tick(8);
        fire(5'b10000); tick(6); fire(5'b0); tick(10);
        check(q.size() == 0, "R7 all records matched", 32'(q.size()), 32'h0);
        fall_en_i = 5'h00; tick(4);

        // R5: disabled source is ignored
        src_en_i = 5'b11101; tick(4);
        fire(5'b00010); tick(10);
        check(empty_o == 1'b1, "R5 disabled source no record", 32'(empty_o), 32'h1);
        fire(5'b0); tick(10);
        check(empty_o == 1'b1, "R5 still empty", 32'(empty_o), 32'h1);
        check(irq_o == 1'b0, "R10 irq low when empty", 32'(irq_o), 32'h0);
        src_en_i = 5'h1f; tick(4);

        // R8: pop on empty changes nothing
        mon_en = 1'b0; tick(2);
        force_pop = 1'b1; tick(3); force_pop = 1'b0; tick(2);
        check(empty_o == 1'b1, "R8 pop on empty", 32'(empty_o), 32'h1);
        mon_en = 1'b1;
        fire(5'b01000); tick(6); fire(5'b0); tick(10);
        check(q.size() == 0 && empty_o, "R8 single record after empty pop", 32'(q.size()), 32'h0);

        // R9: overflow
        mon_en = 1'b0; tick(2);
        for (int k = 0; k < 9; k++) begin
            fire(5'b00001); tick(2);
            fire(5'b0);     tick(6);
        end
        tick(4);
        check(full_o == 1'b1, "R9 full", 32'(full_o), 32'h1);
        check(ovf_o == 1'b1, "R9 overflow set", 32'(ovf_o), 32'h1);
        check(irq_o == 1'b1, "R10 irq while full", 32'(irq_o), 32'h1);
        tick(12);
        check(ovf_o == 1'b1, "R9 overflow sticky", 32'(ovf_o), 32'h1);
        void'(q.pop_back());
        ovf_clr_i = 1'b1; tick(1); ovf_clr_i = 1'b0;
        check(ovf_o == 1'b0, "R9 overflow cleared", 32'(ovf_o), 32'h0);
        mon_en = 1'b1; tick(20);
        check(empty_o == 1'b1 && full_o == 1'b0, "R8 drained", 32'({full_o, empty_o}), 32'h1);
        check(q.size() == 0, "R9 ninth record dropped", 32'(q.size()), 32'h0);
        check(irq_o == 1'b0, "R10 irq low after drain", 32'(irq_o), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule